// File: doc/BRIEF.md
# External Bus Write Cycle Controller

This controller runs single write cycles on an asynchronous external memory or peripheral bus. It is clocked by the bus clock. The core side presents one request, made of an address, a data word, an extension mode, a wait-state count and a hold flag. The controller then drives an active-low chip select, the address, the write data with an active-low output enable, and an active-low write strobe.

Each access can be stretched in one of three ways. The first is a programmed count of wait states. The second is an external acknowledge line that holds the cycle while it is low. The third combines the two: the wait states are counted out first, and only then is the acknowledge line sampled. Once acknowledge is seen high, the strobe stays low for two more bus cycles. An optional hold cycle keeps the data driven for one extra bus cycle after the strobe ends.

The requester sees `busy` while a cycle is in flight and a one-cycle `done` pulse when chip select is released. All bus outputs come straight from flops. The write strobe flop is clocked on the falling edge of the bus clock; every other flop is clocked on the rising edge.

Top module: `ext_wr_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, `cs_n`, `wr_n` and `oe_n` are 1, and `busy` and `done` are 0.
- R2: A request is taken at a rising edge only when `busy` is 0. A `req_valid` seen while `busy` is 1 has no effect on `addr_out`, `data_out` or the cycle timing.
- R3: At the accepting edge (edge 0), `cs_n` falls and `addr_out`/`data_out` take the request values. Both stay stable while `cs_n` is low. `wr_n` falls only at the falling edge after edge 1.
- R4: With `req_mode` = 2'b00 (wait states only), the strobe lasts W+1 bus cycles, where W is `req_waits` (0 to 7). `ack_in` is ignored in this mode.
- R5: With `req_mode` = 2'b01 (acknowledge only), `ack_in` is sampled at each rising edge from edge 2 on. If edge p is the first such edge that sees `ack_in` high, the strobe lasts p+1 cycles, so at least 3.
- R6: With `req_mode` = 2'b10 or 2'b11 (combined), the W wait states are counted first, and `ack_in` is sampled from edge W+3 on. If edge p is the first such edge that sees `ack_in` high, the strobe lasts p+1 cycles.
- R7: `wr_n` changes only at falling edges of `clk`. For a strobe of L cycles, it is low from the falling edge after edge 1 to the falling edge after edge L+1.
- R8: `oe_n` falls at edge 2, the first rising edge after `wr_n` falls. It rises at edge L+2 when `req_hold` is 0, and at edge L+3 when `req_hold` is 1.
- R9: `cs_n` rises at the same edge as `oe_n`, so `wr_n` is always high again before chip select is released.
- R10: `done` is high for exactly one cycle, starting at the edge where `cs_n` rises. `busy` is high from the accepting edge up to that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request write data |
| req_mode | input | 2 | Extension mode: 00 wait states, 01 acknowledge, 10/11 combined |
| req_waits | input | WSW | Wait-state count W |
| req_hold | input | 1 | Add one data hold cycle |
| ack_in | input | 1 | External acknowledge, low holds the access |
| busy | output | 1 | Cycle in flight |
| done | output | 1 | One-cycle pulse at chip select release |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Data output enable, active low |
| addr_out | output | AW | Bus address |
| data_out | output | DW | Bus write data |

## Verification
The write cycle is driven in all four mode codes, with wait counts at 0, at 7 and in between. In acknowledge modes, `ack_in` rises either before sampling begins or many cycles later. That separates the minimum three-cycle acknowledge strobe from a genuinely held one, and it shows whether the wait count comes before acknowledge sampling in combined mode. In wait-only mode, `ack_in` toggles randomly, so any dependence on it shows up as a changed strobe length. Runs with the hold flag set and cleared tell the extra data cycle apart from the plain release. A request raised in the middle of a cycle shows whether busy-time requests are dropped.

// File: rtl/ext_wr_ctrl.sv
`timescale 1ns/1ps
module ext_wr_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [1:0]    req_mode,
  input  logic [WSW-1:0] req_waits,
  input  logic          req_hold,
  input  logic          ack_in,
  output logic          busy,
  output logic          done,
  output logic          cs_n,
  output logic          wr_n,
  output logic          oe_n,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WAIT, ST_ACK, ST_FIN, ST_TAIL, ST_HOLD
  } st_t;

  st_t           st;
  logic [WSW-1:0] cnt;
  logic          fin2;
  logic [1:0]    mode_q;
  logic          hold_q;

  wire strobe  = (st == ST_WAIT) || (st == ST_ACK) || (st == ST_FIN);
  wire use_ws  = (mode_q != 2'b01);
  wire use_ack = (mode_q != 2'b00);

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      fin2     <= 1'b0;
      mode_q   <= 2'b00;
      hold_q   <= 1'b0;
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      done     <= 1'b0;
      addr_out <= '0;
      data_out <= '0;
    end else begin
      done <= 1'b0;
      oe_n <= !(strobe || (st == ST_TAIL && hold_q));
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st       <= ST_SETUP;
          cs_n     <= 1'b0;
          addr_out <= req_addr;
          data_out <= req_data;
          mode_q   <= req_mode;
          hold_q   <= req_hold;
          cnt      <= req_waits;
          fin2     <= 1'b0;
        end
        ST_SETUP: st <= use_ws ? ST_WAIT : ST_ACK;
        ST_WAIT:
          if (cnt == '0) st <= use_ack ? ST_ACK : ST_TAIL;
          else cnt <= cnt - 1'b1;
        ST_ACK: if (ack_in) begin
          st   <= ST_FIN;
          fin2 <= 1'b0;
        end
        ST_FIN:
          if (fin2) st <= ST_TAIL;
          else fin2 <= 1'b1;
        ST_TAIL:
          if (hold_q) st <= ST_HOLD;
          else begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
            done <= 1'b1;
          end
        ST_HOLD: begin
          st   <= ST_IDLE;
          cs_n <= 1'b1;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (rst) wr_n <= 1'b1;
    else     wr_n <= !strobe;
  end

endmodule

// File: rtl/ext_wr_ctrl_chk.sv
`timescale 1ns/1ps
module ext_wr_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          wr_n,
  input logic          oe_n,
  input logic          done,
  input logic          busy,
  input logic [AW-1:0] addr_out,
  input logic [DW-1:0] data_out
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (cs_n && oe_n && !busy && !done)); // R1

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr_out) && $stable(data_out))); // R3

  AST_CS_LEADS_WR: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(!cs_n)); // R3

  AST_OE_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> $past(!wr_n)); // R8

  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !cs_n); // R8

  AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !cs_n); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(!cs_n) && !busy)); // R10

endmodule

bind ext_wr_ctrl ext_wr_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n),
  .done(done), .busy(busy), .addr_out(addr_out), .data_out(data_out)
);

// File: tb/ext_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_wr_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0] req_mode = 2'b00;
  logic [2:0] req_waits = 3'd0;
  logic req_hold = 1'b0;
  logic ack_in = 1'b0;
  logic busy, done, cs_n, wr_n, oe_n;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] data_out;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  ext_wr_ctrl #(.AW(AW), .DW(DW), .WSW(3)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_mode(req_mode), .req_waits(req_waits),
    .req_hold(req_hold), .ack_in(ack_in), .busy(busy), .done(done),
    .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n), .addr_out(addr_out),
    .data_out(data_out)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int idx, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: cycle %0d got %0d expected %0d", rq, what, idx, act, exp);
    end
  endtask

  // strobe length in bus cycles; t is the first rising edge (after accept) with ack high
  function automatic int exp_len(input logic [1:0] m, input int w, input int t);
    int s, p;
    if (m == 2'b00) return w + 1;
    s = (m == 2'b01) ? 1 : w + 2;
    p = (t > s + 1) ? t : s + 1;
    return p + 1;
  endfunction

  task automatic run_txn(input logic [1:0] m, input int w, input bit h, input int t,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int len = exp_len(m, w, t);
    int rel = 2 + len + int'(h);
    int bcs = -1, bwr = -1, boe = -1, bdn = -1, bbz = -1, bad = -1;
    int vcs = 0, vwr = 0, voe = 0, vdn = 0, vbz = 0, vad = 0;
    string wtag;
    wtag = (m == 2'b00) ? "R4 R7" : (m == 2'b01) ? "R5 R7" : "R6 R7";
    @(negedge clk);
    req_addr = a; req_data = d; req_mode = m; req_waits = w[2:0];
    req_hold = h; req_valid = 1'b1;
    for (int i = 0; i <= rel + 1; i++) begin
      @(posedge clk); #1;
      if (i == 0) req_valid = 1'b0;
      if (cs_n !== (i >= rel) && bcs < 0) begin bcs = i; vcs = int'(cs_n); end
      if (oe_n !== !(i >= 2 && i < rel) && boe < 0) begin boe = i; voe = int'(oe_n); end
      if (done !== (i == rel) && bdn < 0) begin bdn = i; vdn = int'(done); end
      if (busy !== (i < rel) && bbz < 0) begin bbz = i; vbz = int'(busy); end
      if (i < rel && (addr_out !== a || data_out !== d) && bad < 0) begin
        bad = i; vad = int'(addr_out);
      end
      @(negedge clk); #1;
      if (wr_n !== !(i >= 1 && i <= len) && bwr < 0) begin bwr = i; vwr = int'(wr_n); end
      if (poke && i == 2) begin req_valid = 1'b1; req_addr = ~a; req_data = ~d; end
      if (poke && i == 3) req_valid = 1'b0;
      ack_in = (m == 2'b00) ? 1'($urandom % 2) : (i + 1 >= t);
    end
    ack_in = 1'b0;
    chk(bcs < 0, "R3 R9", "cs_n window", bcs, vcs, 1 - vcs);
    chk(bwr < 0, wtag, "wr_n window", bwr, vwr, 1 - vwr);
    chk(boe < 0, "R8", "oe_n window", boe, voe, 1 - voe);
    chk(bdn < 0, "R10", "done pulse", bdn, vdn, 1 - vdn);
    chk(bbz < 0, "R10", "busy window", bbz, vbz, 1 - vbz);
    chk(bad < 0, poke ? "R2" : "R3", "addr/data hold", bad, vad, int'(a));
  endtask

  initial begin
    #500000;
    nfail++;
    $display("FAIL R1 watchdog expired: got 0 expected 1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n === 1'b1, "R1", "reset cs_n", 0, int'(cs_n), 1);
    chk(oe_n === 1'b1, "R1", "reset oe_n", 0, int'(oe_n), 1);
    chk(busy === 1'b0, "R1", "reset busy", 0, int'(busy), 0);
    chk(done === 1'b0, "R1", "reset done", 0, int'(done), 0);
    @(negedge clk); #1;
    chk(wr_n === 1'b1, "R1", "reset wr_n", 0, int'(wr_n), 1);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (2) @(posedge clk);

    run_txn(2'b00, 0, 1'b0, 0, 16'h1234, 16'hA5A5, 1'b0); // R4 min strobe
    run_txn(2'b00, 7, 1'b0, 0, 16'h0F0F, 16'h5A5A, 1'b0); // R4 max waits
    run_txn(2'b00, 3, 1'b1, 0, 16'h00FF, 16'h1111, 1'b0); // R8 hold
    run_txn(2'b01, 0, 1'b0, 0, 16'hBEEF, 16'hCAFE, 1'b0); // R5 ack already high
    run_txn(2'b01, 0, 1'b1, 9, 16'h4321, 16'h8765, 1'b0); // R5 ack held low
    run_txn(2'b10, 3, 1'b0, 0, 16'h2222, 16'h3333, 1'b0); // R6 waits first
    run_txn(2'b10, 2, 1'b1, 12, 16'h7777, 16'h8888, 1'b0); // R6 ack late
    run_txn(2'b11, 5, 1'b0, 3, 16'h9999, 16'hAAAA, 1'b0); // R6 ack early, ignored during waits
    run_txn(2'b00, 6, 1'b0, 0, 16'hC0DE, 16'hF00D, 1'b1); // R2 request while busy

    for (int k = 0; k < 40; k++) begin
      run_txn(2'($urandom % 4), int'($urandom % 8), 1'($urandom % 2),
              int'($urandom % 14), 16'($urandom), 16'($urandom), 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule